// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with two byte-wide registers: an 8-bit up-counter and an 8-bit control/status register. Software reads either register as a plain byte. A write, however, is a 16-bit word whose upper byte must hold a key that belongs to the register being written. A write with any other upper byte is dropped and changes nothing. This stops a stray store from reloading or reconfiguring the timer.

When enabled, the counter advances once per prescaler period. A 3-bit clock-select field picks one of eight power-of-two ratios, from 1/32 to 1/4096 of the input clock. When the counter wraps from 0xFF to 0x00, the block latches an overflow flag and drives a single-cycle pulse that the system reset controller or an interrupt controller can consume. Software keeps the system alive by reloading the counter, with the counter key, before it wraps.

A build-time option widens the write port to 32 bits. In that form the key sits in the top byte of the word.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the counter reads 0x00, the control/status register reads 0x00 (timer disabled, flag clear, clock-select 0), and the pulse output is low.
- R2: A write to the counter (address 0) whose key byte (bits 15:8) is 0x5A loads bits 7:0 into the counter. A read at address 0 returns the counter byte.
- R3: A write to the control/status register (address 1) whose key byte is 0xA5 loads the enable bit (bit 7) and the clock-select field (bits 2:0) from bits 7:0. On a read at address 1, bit 7 is the enable, bit 6 is the overflow flag, bits 2:0 are the clock-select field, and bits 5:3 read 0.
- R4: A write whose key byte is not the key of the addressed register is ignored, and the register keeps its value. This includes writing one register with the other register's key.
- R5: While the timer is enabled, the counter increments once every 2^(PRE_SHIFT+sel) clock cycles, where sel is the clock-select value (default PRE_SHIFT=5 gives 1/32 for sel 0 up to 1/4096 for sel 7). The first increment comes one full period after the prescaler restarts.
- R6: While the timer is disabled, the counter holds its value and no pulse is produced.
- R7: The counter wrap from 0xFF to 0x00 sets the overflow flag and drives wdt_pulse_o high for exactly one clock cycle, on the same edge that the counter becomes 0x00.
- R8: A control write with bit 6 = 0 clears the overflow flag. A control write with bit 6 = 1 leaves the flag unchanged.
- R9: A counter write, or a control write that changes the clock-select value, restarts the prescaler. The next increment then comes a full new period after that write.
- R10: With WIDE_BUS=1 the write port is 32 bits wide and the key is taken from bits 31:24. A key placed in bits 15:8 is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 counter, 1 control/status |
| bus_wdata | input | 16 (32 if WIDE_BUS) | Write word: key in the top byte, value in bits 7:0 |
| bus_rdata | output | 8 | Byte of the selected register (combinational) |
| wdt_pulse_o | output | 1 | One-cycle overflow pulse toward reset or interrupt logic |

## Verification
The main timing path is tested by sweeping all eight clock-select codes. For each code the counter is preloaded to 0xFE, and the bench checks that the pulse arrives after exactly twice the computed period. This separates every ratio from its neighbours and catches off-by-one errors in the prescaler terminal count. A full 256-step wrap from 0x00 at the fastest ratio shows that the counter covers its whole range rather than wrapping early. Mid-period reloads and a mid-period clock-select change check where the counter sits one cycle before and at the expected increment, which proves that the prescaler restarts. The other patterns each target one rule: keys swapped between the two registers, all-ones control writes against the flag, and a wide-bus instance with the key placed in the wrong byte.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

    localparam logic [7:0] CNT_KEY = 8'h5A;
    localparam logic [7:0] CSR_KEY = 8'hA5;

    typedef enum logic {
        REG_COUNT = 1'b0,
        REG_CTRL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       run;
        logic       ovf;
        logic [2:0] div;
    } ctrl_t;

    // Terminal count of the prescaler for a given shift and select.
    function automatic logic [31:0] div_limit(input int shift, input logic [2:0] div);
        return (32'd1 << (shift + int'(div))) - 32'd1;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {c.run, c.ovf, 3'b000, c.div};
    endfunction

endpackage

// File: rtl/wdog_key_gate.sv
module wdog_key_gate
    import wdog_keyed_pkg::*;
#(
    parameter bit WIDE_BUS = 1'b0,
    localparam int BW = WIDE_BUS ? 32 : 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          addr,
    input  logic [BW-1:0] wdata,
    output logic          cnt_we,
    output logic          ctrl_we,
    output logic [7:0]    wbyte
);
    logic [7:0] key;
    logic       unused_mid;

    generate
        if (WIDE_BUS) begin : g_wide
            assign key = wdata[31:24];
        end else begin : g_narrow
            assign key = wdata[15:8];
        end
    endgenerate

    assign unused_mid = ^wdata;
    assign wbyte      = wdata[7:0];
    assign cnt_we     = wr && (reg_sel_e'(addr) == REG_COUNT) && (key == CNT_KEY);
    assign ctrl_we    = wr && (reg_sel_e'(addr) == REG_CTRL)  && (key == CSR_KEY);

    // R4: a key mismatch never yields a write strobe
    assert_bad_key_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && key != CNT_KEY && key != CSR_KEY) |-> !(cnt_we || ctrl_we));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({cnt_we, ctrl_we}) <= 1);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_keyed_pkg::*;
#(
    parameter int PRE_SHIFT = 5,
    localparam int PRE_W = PRE_SHIFT + 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] div,
    input  logic       restart,
    output logic       tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [31:0]      lim32;
    logic             unused_lim;

    assign lim32      = div_limit(PRE_SHIFT, div);
    assign unused_lim = ^lim32;
    assign tick       = run && !restart && (pre_cnt == lim32[PRE_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R6: no tick while stopped
    assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        tick |-> run);

    // R9: a restart puts the divider back at zero
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> pre_cnt == '0);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       tick,
    output logic [7:0] cnt,
    output logic       wrap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= 8'h00;
            wrap <= 1'b0;
        end else begin
            wrap <= tick && !load && (cnt == 8'hFF);
            if (load) begin
                cnt <= load_val;
            end else if (tick) begin
                cnt <= cnt + 8'h01;
            end
        end
    end

    // R2: a keyed counter write lands on the next edge
    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

    // R6: without a tick or load the count holds
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt));

    // R7: the wrap pulse lasts one cycle and leaves the count at zero
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);

    assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |-> cnt == 8'h00);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_keyed_pkg::*;
#(
    parameter int PRE_SHIFT = 5,
    parameter bit WIDE_BUS  = 1'b0,
    localparam int BW = WIDE_BUS ? 32 : 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          wdt_pulse_o
);
    logic       cnt_we;
    logic       ctrl_we;
    logic [7:0] wbyte;
    logic       div_change;
    logic       restart;
    logic       tick;
    logic [7:0] cnt;
    logic       wrap;
    ctrl_t      ctrl;

    wdog_key_gate #(.WIDE_BUS(WIDE_BUS)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cnt_we  (cnt_we),
        .ctrl_we (ctrl_we),
        .wbyte   (wbyte)
    );

    assign div_change = ctrl_we && (wbyte[2:0] != ctrl.div);
    assign restart    = cnt_we || div_change;

    wdog_prescaler #(.PRE_SHIFT(PRE_SHIFT)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .div     (ctrl.div),
        .restart (restart),
        .tick    (tick)
    );

    wdog_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_we),
        .load_val (wbyte),
        .tick     (tick),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl.run <= wbyte[7];
                ctrl.div <= wbyte[2:0];
            end
            if (tick && !cnt_we && cnt == 8'hFF) begin
                ctrl.ovf <= 1'b1;
            end else if (ctrl_we && !wbyte[6]) begin
                ctrl.ovf <= 1'b0;
            end
        end
    end

    assign bus_rdata   = (reg_sel_e'(bus_addr) == REG_COUNT) ? cnt : ctrl_to_byte(ctrl);
    assign wdt_pulse_o = wrap;

    // R7: the pulse is always accompanied by the latched flag
    assert_flag_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wdt_pulse_o |-> ctrl.ovf);

    // R8: writing a one to the flag never clears it
    assert_flag_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && wbyte[6] && ctrl.ovf) |=> ctrl.ovf);

    // R4: an unkeyed cycle leaves the control register alone apart from the flag
    assert_ctrl_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> (ctrl.run == $past(ctrl.run) && ctrl.div == $past(ctrl.div)));

endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT      = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        addr = 1'b0;
    logic [15:0] wdata = 16'h0000;
    logic [7:0]  rdata;
    logic        pulse;

    logic        w_wr = 1'b0;
    logic        w_addr = 1'b0;
    logic [31:0] w_wdata = 32'h0;
    logic [7:0]  w_rdata;
    logic        w_pulse;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_keyed #(.PRE_SHIFT(SHIFT), .WIDE_BUS(1'b0)) u_wdog_keyed (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .wdt_pulse_o(pulse)
    );

    wdog_keyed #(.PRE_SHIFT(SHIFT), .WIDE_BUS(1'b1)) u_wdog_keyed_wide (
        .clk(clk), .rst(rst), .bus_wr(w_wr), .bus_addr(w_addr),
        .bus_wdata(w_wdata), .bus_rdata(w_rdata), .wdt_pulse_o(w_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wide_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        w_wr = 1'b1; w_addr = a; w_wdata = d;
        @(negedge clk);
        w_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    // Counts negedges after a write until the pulse shows; returns -1 if absent.
    task automatic wait_pulse(input int limit, output int k);
        k = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (pulse) begin
                k = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int k;
        int per;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(1'b0, v); check("R1 counter", v, 8'h00);
        bus_read(1'b1, v); check("R1 ctrl", v, 8'h00);
        check("R1 pulse", pulse, 0);

        // R2 keyed counter write with timer stopped
        bus_write(1'b0, 16'h5A37);
        bus_read(1'b0, v); check("R2 load", v, 8'h37);

        // R4 wrong keys
        bus_write(1'b0, 16'hA599);
        bus_read(1'b0, v); check("R4 counter swapped key", v, 8'h37);
        bus_write(1'b0, 16'h0011);
        bus_read(1'b0, v); check("R4 counter zero key", v, 8'h37);
        bus_write(1'b1, 16'h5A83);
        bus_read(1'b1, v); check("R4 ctrl swapped key", v, 8'h00);

        // R6 stopped timer holds
        repeat (300) @(negedge clk);
        bus_read(1'b0, v); check("R6 hold", v, 8'h37);
        check("R6 no pulse", pulse, 0);

        // R3 all-ones control write: flag stays 0, bits 5:3 read 0
        bus_write(1'b1, 16'hA5FF);
        bus_read(1'b1, v); check("R3 ctrl readback", v, 8'h87);
        bus_write(1'b1, 16'hA500);
        bus_read(1'b1, v); check("R3 ctrl cleared", v, 8'h00);

        // R5 sweep all clock-select codes, preload 0xFE
        for (int s = 0; s < 8; s++) begin
            per = 1 << (SHIFT + s);
            bus_write(1'b1, 16'hA580 | 16'(s));
            bus_write(1'b0, 16'h5AFE);
            wait_pulse(2 * per + 8, k);
            check($sformatf("R5 sel%0d overflow delay", s), k, 2 * per);
            bus_read(1'b0, v); check("R7 counter at zero", v, 8'h00);
            bus_read(1'b1, v); check("R7 flag set", v, 8'hC0 | s);
            @(negedge clk);
            check("R7 pulse one cycle", pulse, 0);
            // R8 writing 1 to flag keeps it, writing 0 clears it
            bus_write(1'b1, 16'hA5C0 | 16'(s));
            bus_read(1'b1, v); check("R8 flag kept", v, 8'hC0 | s);
            bus_write(1'b1, 16'hA580 | 16'(s));
            bus_read(1'b1, v); check("R8 flag cleared", v, 8'h80 | s);
        end

        // R5 full 256-step wrap at sel 0
        bus_write(1'b1, 16'hA580);
        bus_write(1'b0, 16'h5A00);
        wait_pulse(256 * 32 + 8, k);
        check("R5 full wrap", k, 256 * 32);

        // R9 counter reload mid-period restarts prescaler (sel 1, period 64)
        bus_write(1'b1, 16'hA581);
        bus_write(1'b0, 16'h5AFD);
        repeat (30) @(negedge clk);
        bus_write(1'b0, 16'h5AFE);
        repeat (63) @(negedge clk);
        bus_read(1'b0, v); check("R9 reload before tick", v, 8'hFE);
        @(negedge clk);
        bus_read(1'b0, v); check("R9 reload at tick", v, 8'hFF);

        // R9 clock-select change mid-period (sel 0 -> 1)
        bus_write(1'b1, 16'hA580);
        bus_write(1'b0, 16'h5AFE);
        repeat (20) @(negedge clk);
        bus_write(1'b1, 16'hA581);
        repeat (63) @(negedge clk);
        bus_read(1'b0, v); check("R9 select change before tick", v, 8'hFE);
        @(negedge clk);
        bus_read(1'b0, v); check("R9 select change at tick", v, 8'hFF);
        bus_write(1'b1, 16'hA500);

        // R10 wide bus key position
        wide_write(1'b0, 32'h5A000033);
        w_addr = 1'b0; #1;
        check("R10 wide key accepted", w_rdata, 8'h33);
        wide_write(1'b0, 32'h00005A44);
        #1;
        check("R10 low key ignored", w_rdata, 8'h33);
        wide_write(1'b1, 32'hA5000082);
        w_addr = 1'b1; #1;
        check("R10 wide ctrl", w_rdata, 8'h82);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule